// File: doc/BRIEF.md
# Watchdog Timer with Reset-Cause Flags

This block watches for a periodic service sequence from software. If the sequence does not arrive in time, it requests a system reset. Software chooses one of four timeout intervals. The choice can be made only once after each system reset, and later attempts leave it unchanged. To service the watchdog, software writes an arming key and then a confirming key to the key register. A free-running prescaler drives a two-step warning state, so a missed service leads to a one-cycle reset request somewhere between one and two intervals after the last good service.

The same register also keeps two sticky flags that record the cause of the most recent reset: the watchdog or a software request. The surrounding reset controller raises a cause input for the source that fired. The flags stay set through a system reset, because that is when software needs to see them. They clear when software reads the control register or when the external pin reset is applied. The register port is a plain single-cycle read/write port with a one-bit address.

Top module: `wdog_guard`

## Requirements
- R1: Interval code c in bits [1:0] of the control register (address 0) selects a timeout exponent n = BASE_EXP + 2*c. With the default BASE_EXP of 16, code 00 gives 2^16 cycles, 01 gives 2^18, 10 gives 2^20 and 11 gives 2^22.
- R2: The interval code reads as 00 after a system reset or a pin reset.
- R3: After each reset, only the first write to address 0 updates the interval code. Every later write leaves it unchanged, and the code can always be read back in bits [1:0].
- R4: A service is a write of 0xA5 to the key register (address 1), followed later by a write of 0x5A, with no other key-register write in between. If no further service arrives, `wdt_rst_o` pulses between 2^n+1 and 2^(n+1) clock edges after the edge that accepted the 0x5A write.
- R5: A 0x5A write that does not directly follow a 0xA5 write is not a service and does not delay the timeout.
- R6: If services arrive less than 2^n cycles apart, `wdt_rst_o` never pulses.
- R7: `wdt_rst_o` is high for exactly one clock cycle per timeout.
- R8: A cycle with `wd_cause_i` high sets the watchdog flag, read in bit 7 of address 0. A cycle with `sw_cause_i` high sets the software flag, read in bit 5.
- R9: A read of address 0 returns the current flags, and the flags clear at the following edge. The flags keep their value through a system reset, and a pin reset clears them.
- R10: Writes to address 0 never change the flags. Bits 6, 4, 3 and 2 of address 0 read as 0, and address 1 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| pin_rst_ni | input | 1 | External pin reset, active low; clears everything including the flags |
| sys_rst_ni | input | 1 | System reset, active low; clears everything except the flags |
| addr_i | input | 1 | Register select: 0 control/status, 1 key |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe; a read of address 0 clears the flags |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed register |
| wd_cause_i | input | 1 | The reset controller reports a watchdog-caused reset |
| sw_cause_i | input | 1 | The reset controller reports a software-requested reset |
| wdt_rst_o | output | 1 | One-cycle watchdog reset request |

## Verification
The hardest case to reach is the timeout window. It depends on where the free-running prescaler stands at the moment of service, and at the default exponents it is millions of cycles long. The bench builds the block with a base exponent of 2, so the four codes give windows of 4, 16, 64 and 256 cycles. For each code it measures the exact edge count from the confirming key write to the reset pulse. It also keeps a stream of broken key sequences going while the timeout runs, to show that those writes do not delay it.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

   localparam int unsigned REG_DW = 8;

   localparam logic [REG_DW-1:0] KEY_ARM  = 8'hA5;
   localparam logic [REG_DW-1:0] KEY_FIRE = 8'h5A;

   localparam logic ADDR_CTRL = 1'b0;
   localparam logic ADDR_KEY  = 1'b1;

   localparam int unsigned FLAG_WD_BIT = 7;
   localparam int unsigned FLAG_SW_BIT = 5;
   localparam int unsigned NUM_FLAGS   = 2;
   localparam int unsigned FLAG_WD_IDX = 0;
   localparam int unsigned FLAG_SW_IDX = 1;

   typedef enum logic {
      ST_CALM = 1'b0,
      ST_WARN = 1'b1
   } wd_state_e;

   function automatic int unsigned tap_exp(input int unsigned base,
                                           input int unsigned step,
                                           input int unsigned code);
      return base + step * code;
   endfunction

endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler import wdg_pkg::*; #(
   parameter int unsigned BASE_EXP = 16,
   parameter int unsigned EXP_STEP = 2,
   parameter int unsigned SEL_W    = 2
)(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tick_o
);
   localparam int unsigned NUM_SEL = 1 << SEL_W;
   localparam int unsigned CNT_W   = tap_exp(BASE_EXP, EXP_STEP, NUM_SEL - 1);

   logic [CNT_W-1:0]   cnt_q;
   logic [NUM_SEL-1:0] tap_v;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
   end

   for (genvar g = 0; g < NUM_SEL; g++) begin : g_tap
      localparam int unsigned TAP_N = tap_exp(BASE_EXP, EXP_STEP, g);
      assign tap_v[g] = &cnt_q[TAP_N-1:0];
   end

   assign tick_o = tap_v[sel_i];

endmodule

// File: rtl/wdg_key_seq.sv
module wdg_key_seq import wdg_pkg::*; (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              key_wr_i,
   input  logic [REG_DW-1:0] key_data_i,
   output logic              armed_o,
   output logic              service_o
);
   logic armed_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       armed_q <= 1'b0;
      else if (key_wr_i) armed_q <= (key_data_i == KEY_ARM);
   end

   assign service_o = key_wr_i && armed_q && (key_data_i == KEY_FIRE);
   assign armed_o   = armed_q;

endmodule

// File: rtl/wdg_timeout.sv
module wdg_timeout import wdg_pkg::*; (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_i,
   input  logic service_i,
   output logic fire_o
);
   wd_state_e st_q;
   logic      fire_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= ST_CALM;
         fire_q <= 1'b0;
      end else begin
         fire_q <= 1'b0;
         if (service_i) begin
            st_q <= ST_CALM;
         end else if (tick_i) begin
            if (st_q == ST_WARN) begin
               fire_q <= 1'b1;
               st_q   <= ST_CALM;
            end else begin
               st_q <= ST_WARN;
            end
         end
      end
   end

   assign fire_o = fire_q;

endmodule

// File: rtl/wdg_cause_flags.sv
module wdg_cause_flags import wdg_pkg::*; (
   input  logic                 clk_i,
   input  logic                 pin_rst_ni,
   input  logic [NUM_FLAGS-1:0] set_i,
   input  logic                 rd_clr_i,
   output logic [NUM_FLAGS-1:0] flag_o
);
   logic [NUM_FLAGS-1:0] flag_q;

   for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
      always_ff @(posedge clk_i or negedge pin_rst_ni) begin
         if (!pin_rst_ni)   flag_q[g] <= 1'b0;
         else if (set_i[g]) flag_q[g] <= 1'b1;
         else if (rd_clr_i) flag_q[g] <= 1'b0;
      end
   end

   assign flag_o = flag_q;

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard import wdg_pkg::*; #(
   parameter int unsigned BASE_EXP = 16,
   parameter int unsigned EXP_STEP = 2,
   parameter int unsigned SEL_W    = 2
)(
   input  logic              clk_i,
   input  logic              pin_rst_ni,
   input  logic              sys_rst_ni,
   input  logic              addr_i,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [REG_DW-1:0] wdata_i,
   output logic [REG_DW-1:0] rdata_o,
   input  logic              wd_cause_i,
   input  logic              sw_cause_i,
   output logic              wdt_rst_o
);
   initial begin : p_elab_chk
      assert (BASE_EXP >= 1) else $error("BASE_EXP must be at least 1");
      assert (EXP_STEP >= 1) else $error("EXP_STEP must be at least 1");
      assert (SEL_W >= 1 && SEL_W <= 2) else $error("SEL_W must fit below the reserved bits");
   end

   // a pin reset also counts as a system reset for everything but the flags
   logic rst_all_n;
   assign rst_all_n = sys_rst_ni & pin_rst_ni;

   logic                 ctrl_wr, key_wr, ctrl_rd;
   logic [SEL_W-1:0]     sel_q;
   logic                 sel_lock_q;
   logic                 armed_q, service, tick;
   logic [NUM_FLAGS-1:0] flag_q, flag_set;

   assign ctrl_wr = wr_en_i && (addr_i == ADDR_CTRL);
   assign key_wr  = wr_en_i && (addr_i == ADDR_KEY);
   assign ctrl_rd = rd_en_i && (addr_i == ADDR_CTRL);

   always_ff @(posedge clk_i or negedge rst_all_n) begin
      if (!rst_all_n) begin
         sel_q      <= '0;
         sel_lock_q <= 1'b0;
      end else if (ctrl_wr && !sel_lock_q) begin
         sel_q      <= wdata_i[SEL_W-1:0];
         sel_lock_q <= 1'b1;
      end
   end

   wdg_prescaler #(
      .BASE_EXP (BASE_EXP),
      .EXP_STEP (EXP_STEP),
      .SEL_W    (SEL_W)
   ) u_presc (
      .clk_i  (clk_i),
      .rst_ni (rst_all_n),
      .sel_i  (sel_q),
      .tick_o (tick)
   );

   wdg_key_seq u_key (
      .clk_i      (clk_i),
      .rst_ni     (rst_all_n),
      .key_wr_i   (key_wr),
      .key_data_i (wdata_i),
      .armed_o    (armed_q),
      .service_o  (service)
   );

   wdg_timeout u_tmo (
      .clk_i     (clk_i),
      .rst_ni    (rst_all_n),
      .tick_i    (tick),
      .service_i (service),
      .fire_o    (wdt_rst_o)
   );

   always_comb begin
      flag_set              = '0;
      flag_set[FLAG_WD_IDX] = wd_cause_i;
      flag_set[FLAG_SW_IDX] = sw_cause_i;
   end

   wdg_cause_flags u_flags (
      .clk_i      (clk_i),
      .pin_rst_ni (pin_rst_ni),
      .set_i      (flag_set),
      .rd_clr_i   (ctrl_rd),
      .flag_o     (flag_q)
   );

   always_comb begin
      rdata_o = '0;
      if (addr_i == ADDR_CTRL) begin
         rdata_o[FLAG_WD_BIT] = flag_q[FLAG_WD_IDX];
         rdata_o[FLAG_SW_BIT] = flag_q[FLAG_SW_IDX];
         rdata_o[SEL_W-1:0]   = sel_q;
      end
   end

endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk import wdg_pkg::*; #(
   parameter int unsigned SEL_W = 2
)(
   input logic                 clk_i,
   input logic                 rst_all_n,
   input logic                 pin_rst_ni,
   input logic                 addr_i,
   input logic                 wr_en_i,
   input logic                 rd_en_i,
   input logic [REG_DW-1:0]    wdata_i,
   input logic [REG_DW-1:0]    rdata_o,
   input logic                 wd_cause_i,
   input logic                 sw_cause_i,
   input logic                 wdt_rst_o,
   input logic [SEL_W-1:0]     sel_q,
   input logic                 armed_q,
   input logic [NUM_FLAGS-1:0] flag_q
);
   localparam logic [REG_DW-1:0] RSV_MASK = 8'h5C;

   logic wrote_q;
   always_ff @(posedge clk_i or negedge rst_all_n) begin
      if (!rst_all_n)                              wrote_q <= 1'b0;
      else if (wr_en_i && (addr_i == ADDR_CTRL))   wrote_q <= 1'b1;
   end

   a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_all_n)
      wdt_rst_o |=> !wdt_rst_o);

   a_r3_sel_frozen: assert property (@(posedge clk_i) disable iff (!rst_all_n)
      wrote_q |=> $stable(sel_q));

   a_r4_service_quiet: assert property (@(posedge clk_i) disable iff (!rst_all_n)
      (wr_en_i && (addr_i == ADDR_KEY) && (wdata_i == KEY_FIRE) && armed_q) |=> !wdt_rst_o);

   a_r8_wd_capture: assert property (@(posedge clk_i) disable iff (!pin_rst_ni)
      wd_cause_i |=> flag_q[FLAG_WD_IDX]);

   a_r8_sw_capture: assert property (@(posedge clk_i) disable iff (!pin_rst_ni)
      sw_cause_i |=> flag_q[FLAG_SW_IDX]);

   a_r9_wd_read_clear: assert property (@(posedge clk_i) disable iff (!pin_rst_ni)
      (rd_en_i && (addr_i == ADDR_CTRL) && !wd_cause_i) |=> !flag_q[FLAG_WD_IDX]);

   a_r9_sw_read_clear: assert property (@(posedge clk_i) disable iff (!pin_rst_ni)
      (rd_en_i && (addr_i == ADDR_CTRL) && !sw_cause_i) |=> !flag_q[FLAG_SW_IDX]);

   a_r10_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_all_n)
      (addr_i == ADDR_CTRL) |-> ((rdata_o & RSV_MASK) == '0));

   a_r10_key_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_all_n)
      (addr_i == ADDR_KEY) |-> (rdata_o == '0));

endmodule

bind wdog_guard wdog_guard_chk #(.SEL_W(SEL_W)) chk_i (
   .clk_i      (clk_i),
   .rst_all_n  (rst_all_n),
   .pin_rst_ni (pin_rst_ni),
   .addr_i     (addr_i),
   .wr_en_i    (wr_en_i),
   .rd_en_i    (rd_en_i),
   .wdata_i    (wdata_i),
   .rdata_o    (rdata_o),
   .wd_cause_i (wd_cause_i),
   .sw_cause_i (sw_cause_i),
   .wdt_rst_o  (wdt_rst_o),
   .sel_q      (sel_q),
   .armed_q    (armed_q),
   .flag_q     (flag_q)
);

// File: tb/wdog_guard_tb_top.sv
module wdog_guard_tb_top;
   localparam int unsigned TB_BASE = 2;

   logic       clk = 1'b0;
   logic       pin_rst_n = 1'b0;
   logic       sys_rst_n = 1'b0;
   logic       addr = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       wd_cause = 1'b0;
   logic       sw_cause = 1'b0;
   logic       wdt_rst;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int fire_cnt = 0;
   int fire_cyc = 0;
   int long_pulse = 0;
   logic prev_fire = 1'b0;
   logic done = 1'b0;

   always #2 clk = ~clk;

   wdog_guard #(.BASE_EXP(TB_BASE)) dut_i (
      .clk_i      (clk),
      .pin_rst_ni (pin_rst_n),
      .sys_rst_ni (sys_rst_n),
      .addr_i     (addr),
      .wr_en_i    (wr_en),
      .rd_en_i    (rd_en),
      .wdata_i    (wdata),
      .rdata_o    (rdata),
      .wd_cause_i (wd_cause),
      .sw_cause_i (sw_cause),
      .wdt_rst_o  (wdt_rst)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (wdt_rst) begin
         fire_cnt = fire_cnt + 1;
         fire_cyc = cyc;
         if (prev_fire) long_pulse = long_pulse + 1;
      end
      prev_fire = wdt_rst;
   end

   task automatic check(input string req, input bit ok, input int act, input int exp_v);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp_v, exp_v);
      end
   endtask

   task automatic pin_reset();
      @(negedge clk);
      pin_rst_n = 1'b0; sys_rst_n = 1'b0;
      repeat (2) @(negedge clk);
      pin_rst_n = 1'b1; sys_rst_n = 1'b1;
   endtask

   task automatic sys_reset();
      @(negedge clk);
      sys_rst_n = 1'b0;
      repeat (2) @(negedge clk);
      sys_rst_n = 1'b1;
   endtask

   task automatic bus_wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic bus_rd(input logic a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic service(output int t0);
      bus_wr(1'b1, 8'hA5);
      bus_wr(1'b1, 8'h5A);
      t0 = cyc;
   endtask

   task automatic pulse_cause(input bit wd);
      @(negedge clk);
      if (wd) wd_cause = 1'b1; else sw_cause = 1'b1;
      @(negedge clk);
      wd_cause = 1'b0; sw_cause = 1'b0;
   endtask

   task automatic test_reset_state();
      logic [7:0] d;
      pin_reset();
      bus_rd(1'b0, d);
      check("R2 control reads zero after pin reset", d == 8'h00, d, 0);
      check("R7 no reset request after reset", wdt_rst == 1'b0, wdt_rst, 0);
      bus_rd(1'b1, d);
      check("R10 key register reads zero", d == 8'h00, d, 0);
   endtask

   task automatic test_sel_once();
      logic [7:0] d;
      sys_reset();
      bus_wr(1'b0, 8'h02);
      bus_rd(1'b0, d);
      check("R3 first write sets interval", d[1:0] == 2'd2, d[1:0], 2);
      bus_wr(1'b0, 8'h01);
      bus_rd(1'b0, d);
      check("R3 second write ignored", d[1:0] == 2'd2, d[1:0], 2);
      sys_reset();
      bus_rd(1'b0, d);
      check("R2 interval back to 00 after system reset", d[1:0] == 2'd0, d[1:0], 0);
      bus_wr(1'b0, 8'h03);
      bus_rd(1'b0, d);
      check("R3 write accepted again after reset", d[1:0] == 2'd3, d[1:0], 3);
   endtask

   task automatic test_interval(input int code);
      int t0, f0, lo, hi, d, n;
      sys_reset();
      bus_wr(1'b0, 8'(code));
      service(t0);
      f0 = fire_cnt;
      n = TB_BASE + 2 * code;
      lo = (1 << n) + 1;
      hi = 1 << (n + 1);
      while (fire_cnt == f0 && (cyc - t0) < hi + 8) @(negedge clk);
      d = fire_cyc - t0;
      check($sformatf("R1 R4 code %0d timeout fired", code), fire_cnt != f0, fire_cnt - f0, 1);
      check($sformatf("R4 code %0d delay within window low", code), d >= lo, d, lo);
      check($sformatf("R4 code %0d delay within window high", code), d <= hi, d, hi);
      repeat (2) @(negedge clk);
      check("R7 reset pulse one cycle wide", long_pulse == 0, long_pulse, 0);
   endtask

   task automatic test_steady_service();
      int t0, f0;
      sys_reset();
      bus_wr(1'b0, 8'h01);
      f0 = fire_cnt;
      for (int i = 0; i < 30; i++) begin
         service(t0);
         repeat (6) @(negedge clk);
      end
      check("R6 regular service suppresses reset", fire_cnt == f0, fire_cnt - f0, 0);
   endtask

   task automatic test_broken_seq();
      int t0, f0, d, k;
      sys_reset();
      bus_wr(1'b0, 8'h01);
      service(t0);
      f0 = fire_cnt;
      k = 0;
      while (fire_cnt == f0 && (cyc - t0) < 60) begin
         if (k[0]) begin
            bus_wr(1'b1, 8'h5A);
         end else begin
            bus_wr(1'b1, 8'hA5);
            bus_wr(1'b1, 8'h33);
            bus_wr(1'b1, 8'h5A);
         end
         k++;
      end
      d = fire_cyc - t0;
      check("R5 broken sequences do not service", fire_cnt != f0, fire_cnt - f0, 1);
      check("R5 timeout still measured from last good service", d >= 17 && d <= 32, d, 17);
   endtask

   task automatic test_flags();
      logic [7:0] d;
      pin_reset();
      pulse_cause(1'b1);
      bus_rd(1'b0, d);
      check("R8 watchdog flag in bit 7", d == 8'h80, d, 8'h80);
      bus_rd(1'b0, d);
      check("R9 flag cleared by read", d == 8'h00, d, 0);
      pulse_cause(1'b0);
      sys_reset();
      bus_wr(1'b0, 8'h00);
      bus_wr(1'b0, 8'hFF);
      bus_rd(1'b0, d);
      check("R8 R9 R10 software flag kept across system reset, writes ignored", d == 8'h20, d, 8'h20);
      bus_rd(1'b0, d);
      check("R9 software flag cleared by read", d == 8'h00, d, 0);
      bus_wr(1'b0, 8'hA0);
      bus_rd(1'b0, d);
      check("R10 write cannot set flags", d == 8'h00, d, 0);
      pulse_cause(1'b1);
      pulse_cause(1'b0);
      pin_reset();
      bus_rd(1'b0, d);
      check("R9 pin reset clears flags", d == 8'h00, d, 0);
   endtask

   task automatic finish_up();
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_up();
      end
   end

   initial begin
      test_reset_state();
      test_sel_once();
      for (int c = 0; c < 4; c++) test_interval(c);
      test_steady_service();
      test_broken_seq();
      test_flags();
      done = 1'b1;
      finish_up();
   end

endmodule